// File: doc/BRIEF.md
# Pipelined Multi-Channel Coherent I/Q Summer

This block adds together complex samples that arrive side by side from up to forty pulse channels and turns out one coherently accumulated complex sample on every clock. In-phase and quadrature parts are reduced separately, with the result widened so that the full sum never wraps. A run-time pulse count selects how many of the lower-numbered channels take part. The higher channels are forced to zero before any addition.

The reduction is an uneven three-level registered tree. Forty inputs feed seven partial sums, those feed two, and those feed one final sum. This keeps the carry chain short at every level. A valid flag runs beside the data with the same three-cycle delay, so a downstream packer sees an aligned strobe.

Top module: `coh_adder_tree`

## Requirements
- R1: `out_i` equals the sum, as signed 12-bit two's complement values, of the I inputs of every enabled channel, taken from the inputs presented three clock edges earlier.
- R2: `out_q` is formed the same way from the Q inputs. It is independent of the I inputs.
- R3: a channel whose index k satisfies k >= `pulse_count` contributes zero. A count of 0 yields zero sums, and any count of 40 or above enables all forty channels.
- R4: a new sum is accepted on every clock with no gaps. Each result appears exactly three cycles after its inputs, and results from back-to-back inputs follow on consecutive cycles.
- R5: `out_valid` equals `in_valid` delayed by exactly three cycles.
- R6: while `rst_n` is low, `out_valid`, `out_i` and `out_q` are zero, including when reset is asserted in the middle of traffic.
- R7: the 18-bit signed outputs represent every reachable sum without overflow. This covers forty inputs of -2048 (giving -81920) and forty inputs of +2047 (giving 81880).
- R8: channel k occupies bits [12k+11:12k] of `in_i` and of `in_q`. Each channel is weighted once, at its own position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Marks the current input set as a real sample |
| pulse_count | input | 6 | Number of low-numbered channels that take part |
| in_i | input | 480 | Forty signed 12-bit I samples, channel k at bits [12k+11:12k] |
| in_q | input | 480 | Forty signed 12-bit Q samples, same layout |
| out_valid | output | 1 | Valid flag aligned with the sums |
| out_i | output | 18 | Signed accumulated I |
| out_q | output | 18 | Signed accumulated Q |

## Verification
Random full-scale data on all channels exercises the main sum. Opposite I and Q values expose any crossing between the two parts. A walking single-channel impulse separates the bit slices of each lane, and a wrong offset or a doubled lane shows up at once. A sweep of pulse counts (0, 1, 6, 7, 24, 39, 40, 63) lands on both sides of the group boundaries of the first level, so masking that is off by one is caught. All-minimum and all-maximum inputs probe the width of the result. A toggling valid pattern and a mid-stream reset test the alignment of the strobe against the data.

// File: rtl/coh_sum_pkg.sv
package coh_sum_pkg;

    localparam int SAMPLE_W  = 12;
    localparam int MAX_LANES = 40;
    localparam int ACC_W     = SAMPLE_W + $clog2(MAX_LANES);

    typedef struct packed {
        logic signed [ACC_W-1:0] i;
        logic signed [ACC_W-1:0] q;
    } iq_acc_t;

endpackage

// File: rtl/coh_lane_gate.sv
module coh_lane_gate
    import coh_sum_pkg::*;
#(
    parameter int N_LANES = 40,
    parameter int CNT_W   = 6
) (
    input  logic [CNT_W-1:0]            pulse_count,
    input  logic [N_LANES*SAMPLE_W-1:0] raw_i,
    input  logic [N_LANES*SAMPLE_W-1:0] raw_q,
    output iq_acc_t                     lane_o [N_LANES]
);

    localparam int EXT_W = ACC_W - SAMPLE_W;

    for (genvar k = 0; k < N_LANES; k++) begin : g_lane
        logic [SAMPLE_W-1:0] si, sq;
        logic                enabled;

        assign si      = raw_i[k*SAMPLE_W +: SAMPLE_W];
        assign sq      = raw_q[k*SAMPLE_W +: SAMPLE_W];
        assign enabled = (k < int'(pulse_count));

        always_comb begin
            if (enabled) begin
                lane_o[k].i = {{EXT_W{si[SAMPLE_W-1]}}, si};
                lane_o[k].q = {{EXT_W{sq[SAMPLE_W-1]}}, sq};
            end else begin
                lane_o[k] = '0;
            end
        end
    end

endmodule

// File: rtl/coh_sum_stage.sv
module coh_sum_stage
    import coh_sum_pkg::*;
#(
    parameter int N_IN  = 40,
    parameter int GRP   = 6,
    parameter int N_OUT = (N_IN + GRP - 1) / GRP
) (
    input  logic    clk,
    input  logic    rst_n,
    input  iq_acc_t in_v  [N_IN],
    output iq_acc_t out_v [N_OUT]
);

    iq_acc_t sum_d [N_OUT];
    iq_acc_t sum_q [N_OUT];

    always_comb begin
        for (int g = 0; g < N_OUT; g++) begin
            sum_d[g] = '0;
            for (int m = 0; m < GRP; m++) begin
                if (g*GRP + m < N_IN) begin
                    sum_d[g].i = sum_d[g].i + in_v[g*GRP + m].i;
                    sum_d[g].q = sum_d[g].q + in_v[g*GRP + m].q;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int g = 0; g < N_OUT; g++) sum_q[g] <= '0;
        end else begin
            for (int g = 0; g < N_OUT; g++) sum_q[g] <= sum_d[g];
        end
    end

    assign out_v = sum_q;

    logic in_all_zero, out_all_zero;
    always_comb begin
        in_all_zero = 1'b1;
        for (int n = 0; n < N_IN; n++)
            if (in_v[n] != '0) in_all_zero = 1'b0;
        out_all_zero = 1'b1;
        for (int g = 0; g < N_OUT; g++)
            if (out_v[g] != '0) out_all_zero = 1'b0;
    end

    // R1: a level fed only zeros presents zeros one cycle later
    p_zero_prop_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_all_zero |=> out_all_zero);

endmodule

// File: rtl/coh_adder_tree.sv
module coh_adder_tree
    import coh_sum_pkg::*;
#(
    parameter int NUM_LANES = 40,
    parameter int CNT_W     = 6,
    parameter int GRP_A     = 6,
    parameter int GRP_B     = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    input  logic [CNT_W-1:0]              pulse_count,
    input  logic [NUM_LANES*SAMPLE_W-1:0] in_i,
    input  logic [NUM_LANES*SAMPLE_W-1:0] in_q,
    output logic                          out_valid,
    output logic signed [ACC_W-1:0]       out_i,
    output logic signed [ACC_W-1:0]       out_q
);

    localparam int N_L1  = (NUM_LANES + GRP_A - 1) / GRP_A;
    localparam int N_L2  = (N_L1 + GRP_B - 1) / GRP_B;
    localparam int LAT   = 3;
    localparam int LIM_P = NUM_LANES * (2**(SAMPLE_W-1) - 1);
    localparam int LIM_N = -NUM_LANES * (2**(SAMPLE_W-1));

    typedef struct packed {
        logic [LAT-1:0] vld_sr;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    iq_acc_t lanes  [NUM_LANES];
    iq_acc_t lvl1   [N_L1];
    iq_acc_t lvl2   [N_L2];
    iq_acc_t lvl3   [1];

    coh_lane_gate #(.N_LANES(NUM_LANES), .CNT_W(CNT_W)) u_gate (
        .pulse_count (pulse_count),
        .raw_i       (in_i),
        .raw_q       (in_q),
        .lane_o      (lanes)
    );

    coh_sum_stage #(.N_IN(NUM_LANES), .GRP(GRP_A), .N_OUT(N_L1)) u_lvl1 (
        .clk (clk), .rst_n (rst_n), .in_v (lanes), .out_v (lvl1)
    );

    coh_sum_stage #(.N_IN(N_L1), .GRP(GRP_B), .N_OUT(N_L2)) u_lvl2 (
        .clk (clk), .rst_n (rst_n), .in_v (lvl1), .out_v (lvl2)
    );

    coh_sum_stage #(.N_IN(N_L2), .GRP(N_L2), .N_OUT(1)) u_lvl3 (
        .clk (clk), .rst_n (rst_n), .in_v (lvl2), .out_v (lvl3)
    );

    always_comb begin
        ctl_d = ctl_q;
        ctl_d.vld_sr = {ctl_q.vld_sr[LAT-2:0], in_valid};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign out_valid = ctl_q.vld_sr[LAT-1];
    assign out_i     = lvl3[0].i;
    assign out_q     = lvl3[0].q;

    // R5: a valid result always traces back to a valid input three cycles before
    p_valid_lat_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 3));

    // R5: a valid input produces a valid result three cycles later
    p_valid_fwd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ##2 out_valid);

    // R3: a zero pulse count held for three cycles gives a zero sum
    p_count_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pulse_count, 3) == '0 && $past(pulse_count, 2) == '0 &&
         $past(pulse_count, 1) == '0) |-> (out_i == '0 && out_q == '0));

    // R7: the final sums stay inside the reachable range
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(out_i) <= LIM_P && int'(out_i) >= LIM_N &&
         int'(out_q) <= LIM_P && int'(out_q) >= LIM_N));

endmodule

// File: tb/coh_adder_tree_tb.sv
module coh_adder_tree_tb;

    localparam int N  = 40;
    localparam int SW = 12;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic [5:0]      pulse_count = '0;
    logic [N*SW-1:0] in_i = '0;
    logic [N*SW-1:0] in_q = '0;
    logic            out_valid;
    logic signed [17:0] out_i, out_q;

    int  checks = 0;
    int  errors = 0;
    int  cycles = 0;
    bit  done = 1'b0;

    int    vi [N];
    int    vq [N];
    bit    ev [3];
    int    ei [3];
    int    eq [3];
    string et [3];

    always #10 clk = ~clk;

    coh_adder_tree u_dut (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid),
        .pulse_count (pulse_count), .in_i (in_i), .in_q (in_q),
        .out_valid (out_valid), .out_i (out_i), .out_q (out_q)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            errors++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cycles);
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic step(input bit rst_v, input bit v, input int cnt, input string tag);
        int si, sq;
        @(negedge clk);
        checks++;
        if (out_valid !== ev[2] || int'(out_i) != ei[2] || int'(out_q) != eq[2]) begin
            errors++;
            $display("FAIL %s: actual v=%0b i=%0d q=%0d expected v=%0b i=%0d q=%0d",
                     et[2], out_valid, out_i, out_q, ev[2], ei[2], eq[2]);
        end
        rst_n = rst_v;
        in_valid = v;
        pulse_count = 6'(cnt);
        for (int k = 0; k < N; k++) begin
            in_i[k*SW +: SW] = SW'(vi[k]);
            in_q[k*SW +: SW] = SW'(vq[k]);
        end
        si = 0; sq = 0;
        for (int k = 0; k < N; k++)
            if (k < cnt) begin si += vi[k]; sq += vq[k]; end
        if (!rst_v) begin
            for (int s = 0; s < 3; s++) begin ev[s] = 0; ei[s] = 0; eq[s] = 0; et[s] = "R6 reset"; end
        end else begin
            for (int s = 2; s > 0; s--) begin ev[s] = ev[s-1]; ei[s] = ei[s-1]; eq[s] = eq[s-1]; et[s] = et[s-1]; end
            ev[0] = v; ei[0] = si; eq[0] = sq; et[0] = tag;
        end
    endtask

    task automatic fill_rand();
        for (int k = 0; k < N; k++) begin
            vi[k] = int'($urandom_range(4095)) - 2048;
            vq[k] = int'($urandom_range(4095)) - 2048;
        end
    endtask

    task automatic fill_const(input int a, input int b);
        for (int k = 0; k < N; k++) begin vi[k] = a; vq[k] = b; end
    endtask

    initial begin
        for (int s = 0; s < 3; s++) begin ev[s] = 0; ei[s] = 0; eq[s] = 0; et[s] = "R6 reset"; end
        fill_const(0, 0);
        for (int c = 0; c < 4; c++) step(1'b0, 1'b0, 0, "R6 reset");
        // R6: outputs are clear while held in reset
        checks++;
        if (out_valid !== 1'b0 || out_i !== '0 || out_q !== '0) begin
            errors++;
            $display("FAIL R6: actual v=%0b i=%0d q=%0d expected 0 0 0", out_valid, out_i, out_q);
        end

        // R1 R2 R4: random back-to-back data on all channels
        for (int c = 0; c < 30; c++) begin fill_rand(); step(1'b1, 1'b1, 40, "R1 R2 R4 random"); end

        // R2: opposite I and Q
        for (int c = 0; c < 10; c++) begin
            fill_rand();
            for (int k = 0; k < N; k++) vq[k] = (vi[k] == -2048) ? 2047 : -vi[k];
            step(1'b1, 1'b1, 40, "R2 mirrored");
        end

        // R8: walking single-channel impulse
        for (int k = 0; k < N; k++) begin
            fill_const(0, 0);
            vi[k] = k + 1; vq[k] = -(k + 1) * 7;
            step(1'b1, 1'b1, 40, "R8 walk");
        end

        // R3: pulse count sweep across group edges
        foreach (vi[j]) vi[j] = 0;
        begin
            int counts [8] = '{0, 1, 6, 7, 24, 39, 40, 63};
            foreach (counts[c]) begin
                for (int r = 0; r < 5; r++) begin fill_rand(); step(1'b1, 1'b1, counts[c], "R3 count"); end
            end
        end

        // R7: extremes
        fill_const(-2048, 2047);
        for (int c = 0; c < 4; c++) step(1'b1, 1'b1, 40, "R7 extreme min/max");
        fill_const(2047, -2048);
        for (int c = 0; c < 4; c++) step(1'b1, 1'b1, 63, "R7 extreme max/min");

        // R5: toggling valid pattern
        for (int c = 0; c < 30; c++) begin
            fill_rand();
            step(1'b1, ((c % 3) != 1) ^ (c > 15), 40, "R5 valid pattern");
        end

        // R6: reset during traffic, then resume
        for (int c = 0; c < 3; c++) begin fill_rand(); step(1'b1, 1'b1, 40, "R6 pre-reset"); end
        fill_rand();
        step(1'b0, 1'b1, 40, "R6 reset");
        step(1'b0, 1'b1, 40, "R6 reset");
        for (int c = 0; c < 8; c++) begin fill_rand(); step(1'b1, 1'b1, 20, "R4 R6 resume"); end

        // drain
        fill_const(0, 0);
        for (int c = 0; c < 5; c++) step(1'b1, 1'b0, 40, "R5 drain");

        done = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule